// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block sits on a processor's 16-bit memory bus and gives software a keyboard and a character display through four device words at fixed addresses: keyboard status (xFE00), keyboard data (xFE02), display status (xFE04) and display data (xFE06). Reads return data in the same cycle. Writes and read side effects take effect at the next rising clock edge. Accesses to any other address are not claimed, so another device on the bus can answer them.

Characters come in from an external keyboard source as a one-cycle valid pulse with a byte. Characters go out to an external display sink over a valid/ready handshake. Each side has a ready flag in bit 15 of its status word, so a polling loop can wait for the status word to turn negative. Each side also has an interrupt enable in bit 14. Reading the keyboard data word clears the keyboard flag. Writing the display data word clears the display flag until the sink takes the byte. A single interrupt request is raised whenever a ready flag and its enable are both set.

Top module: `console_io_regs`

## Requirements
- R1: `busHit` is 1 only while `busRd` or `busWr` is 1 and `busAddr` is one of xFE00, xFE02, xFE04 or xFE06. Any other access leaves `busHit` at 0, reads as `busRdata` = 0 and changes no state.
- R2: After reset:
  - the keyboard status reads x0000;
  - the display status reads x8000 (ready set, enable clear);
  - both data words read x0000;
  - `dispValid` and `irq` are 0.
- R3: A cycle with `keyValid` = 1 stores `keyByte` and sets keyboard status bit 15 from the next cycle on. A read of xFE02 returns the stored byte in bits [7:0], with bits [15:8] zero.
- R4: A read of xFE02 without a key arrival in the same cycle returns the stored byte and clears keyboard status bit 15 from the next cycle on.
- R5: When a key arrives in the same cycle as a read of xFE02:
  - the read returns the previous byte;
  - the new byte is stored;
  - keyboard status bit 15 stays 1.
- R6: A write to xFE06 while display status bit 15 is 1 has three effects from the next cycle on:
  - bits [7:0] of the write data appear on `dispByte`;
  - `dispValid` rises;
  - display status bit 15 clears.
  A read of xFE06 returns the last accepted byte with bits [15:8] zero.
- R7: `dispValid` and `dispByte` hold until a cycle in which `dispReady` is 1. From the following cycle, `dispValid` is 0 and display status bit 15 is 1.
- R8: A write to xFE06 while display status bit 15 is 0 is ignored: `dispByte` is unchanged.
- R9: In both status words only bit 14 (interrupt enable) is writable, bit 15 is the ready flag, and all other bits read 0. Writes to xFE02 have no effect.
- R10: `irq` = (keyboard ready AND keyboard enable) OR (display ready AND display enable), taken from the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus word address |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Read data, same cycle; 0 when not claimed |
| busHit | output | 1 | Access claimed by this block |
| keyValid | input | 1 | Keyboard byte present this cycle |
| keyByte | input | 8 | Keyboard byte |
| dispValid | output | 1 | Display byte pending for the sink |
| dispByte | output | 8 | Display byte |
| dispReady | input | 1 | Sink accepts the pending byte this cycle |
| irq | output | 1 | Interrupt request |

## Verification
Two keyboard events can land in the same clock: the arrival of a new character and a software read of the keyboard data word, which would clear the ready flag. The bench forces this collision on purpose in a directed step. The random phase also raises `keyValid` independently of the bus operation it picks, so the collision recurs. The reference model gives the arrival priority. It expects the read to return the old byte, the flag to stay set and the new byte to read back on the following access.

// File: rtl/console_io_pkg.sv
package console_io_pkg;

  // Strobes issued by control to the datapath, one per state change.
  typedef struct packed {
    logic kbdLoad;
    logic kbdClear;
    logic kbdIeWr;
    logic dispIeWr;
    logic dispLoad;
    logic dispDone;
  } strobes_t;

  // Display state fed back from the datapath to control.
  typedef struct packed {
    logic dispRdy;
    logic dispPend;
  } dispState_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } readSel_t;

endpackage

// File: rtl/console_io_ctrl.sv
module console_io_ctrl
  import console_io_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 'hFE00,
  parameter int ADDR_STRIDE = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              keyValid,
  input  logic              dispReady,
  input  dispState_t        dState,
  output strobes_t          strobes,
  output readSel_t          readSel,
  output logic              busHit
);

  localparam int NUM_REGS = 4;
  localparam int IDX_KSTAT = 0;
  localparam int IDX_KDATA = 1;
  localparam int IDX_DSTAT = 2;
  localparam int IDX_DDATA = 3;

  logic [NUM_REGS-1:0] match;

  // One comparator per device word.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_decode
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE_ADDR + i * ADDR_STRIDE);
    assign match[i] = (busAddr == REG_ADDR);
  end

  logic access;
  assign access = busRd | busWr;
  assign busHit = access & (|match);

  always_comb begin
    readSel = SEL_NONE;
    if (busRd) begin
      if      (match[IDX_KSTAT]) readSel = SEL_KSTAT;
      else if (match[IDX_KDATA]) readSel = SEL_KDATA;
      else if (match[IDX_DSTAT]) readSel = SEL_DSTAT;
      else if (match[IDX_DDATA]) readSel = SEL_DDATA;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.kbdLoad  = keyValid;
    strobes.kbdClear = busRd & match[IDX_KDATA];
    strobes.kbdIeWr  = busWr & match[IDX_KSTAT];
    strobes.dispIeWr = busWr & match[IDX_DSTAT];
    strobes.dispLoad = busWr & match[IDX_DDATA] & dState.dispRdy;
    strobes.dispDone = dState.dispPend & dispReady;
  end

endmodule

// File: rtl/console_io_dpath.sv
module console_io_dpath
  import console_io_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  readSel_t          readSel,
  input  logic              ieVal,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic [CHAR_W-1:0] keyByte,
  output dispState_t        dState,
  output logic [DATA_W-1:0] busRdata,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispByte,
  output logic              irq
);

  logic              kRdyQ, kIeQ, dRdyQ, dIeQ, pendQ;
  logic [CHAR_W-1:0] kByteQ, dByteQ;

  // Keyboard side: an arrival wins over a read-clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kRdyQ  <= 1'b0;
      kByteQ <= '0;
      kIeQ   <= 1'b0;
    end else begin
      if (strobes.kbdLoad) begin
        kRdyQ  <= 1'b1;
        kByteQ <= keyByte;
      end else if (strobes.kbdClear) begin
        kRdyQ <= 1'b0;
      end
      if (strobes.kbdIeWr) kIeQ <= ieVal;
    end
  end

  // Display side: ready and pending never both set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dRdyQ  <= 1'b1;
      pendQ  <= 1'b0;
      dByteQ <= '0;
      dIeQ   <= 1'b0;
    end else begin
      if (strobes.dispLoad) begin
        dByteQ <= wrChar;
        dRdyQ  <= 1'b0;
        pendQ  <= 1'b1;
      end else if (strobes.dispDone) begin
        dRdyQ <= 1'b1;
        pendQ <= 1'b0;
      end
      if (strobes.dispIeWr) dIeQ <= ieVal;
    end
  end

  function automatic logic [DATA_W-1:0] statusWord(input logic rdy, input logic ie);
    logic [DATA_W-1:0] w;
    w            = '0;
    w[READY_BIT] = rdy;
    w[IE_BIT]    = ie;
    return w;
  endfunction

  always_comb begin
    unique case (readSel)
      SEL_KSTAT: busRdata = statusWord(kRdyQ, kIeQ);
      SEL_KDATA: busRdata = DATA_W'(kByteQ);
      SEL_DSTAT: busRdata = statusWord(dRdyQ, dIeQ);
      SEL_DDATA: busRdata = DATA_W'(dByteQ);
      default:   busRdata = '0;
    endcase
  end

  assign dState.dispRdy  = dRdyQ;
  assign dState.dispPend = pendQ;
  assign dispValid       = pendQ;
  assign dispByte        = dByteQ;
  assign irq             = (kRdyQ & kIeQ) | (dRdyQ & dIeQ);

  AST_KBD_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.kbdLoad |=> kRdyQ); // R3
  AST_KBD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kbdClear && !strobes.kbdLoad) |=> !kRdyQ); // R4
  AST_DISP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dRdyQ && pendQ)); // R6
  AST_DISP_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dispDone |=> (dRdyQ && !pendQ)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |=> $stable(dByteQ)); // R8

endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import console_io_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CHAR_W      = 8,
  parameter int BASE_ADDR   = 'hFE00,
  parameter int ADDR_STRIDE = 2,
  parameter int READY_BIT   = 15,
  parameter int IE_BIT      = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busHit,
  input  logic              keyValid,
  input  logic [CHAR_W-1:0] keyByte,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispByte,
  input  logic              dispReady,
  output logic              irq
);

  strobes_t   strobes;
  readSel_t   readSel;
  dispState_t dState;

  console_io_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ADDR_STRIDE(ADDR_STRIDE)
  ) i_ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .keyValid(keyValid), .dispReady(dispReady), .dState(dState),
    .strobes(strobes), .readSel(readSel), .busHit(busHit)
  );

  console_io_dpath #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_BIT(READY_BIT), .IE_BIT(IE_BIT)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .readSel(readSel),
    .ieVal(busWdata[IE_BIT]), .wrChar(busWdata[CHAR_W-1:0]), .keyByte(keyByte),
    .dState(dState), .busRdata(busRdata), .dispValid(dispValid),
    .dispByte(dispByte), .irq(irq)
  );

  AST_NO_HIT_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |-> (!busHit && busRdata == '0)); // R1

endmodule

// File: tb/test_console_io_regs.sv
`timescale 1ns/1ps
module test_console_io_regs;

  localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02, A_DS = 16'hFE04, A_DD = 16'hFE06;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] busAddr = '0, busWdata = '0;
  logic busRd = 1'b0, busWr = 1'b0, keyValid = 1'b0, dispReady = 1'b0;
  logic [7:0] keyByte = '0;
  logic [15:0] busRdata;
  logic busHit, dispValid, irq;
  logic [7:0] dispByte;

  int nTests = 0, nFail = 0;
  string forceTag = "";

  // Reference model state
  logic mKRdy, mKIe, mDRdy, mDIe, mPend;
  logic [7:0] mKByte, mDByte;

  always #2.5 clk = ~clk;

  console_io_regs i_console_io_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busHit(busHit),
    .keyValid(keyValid), .keyByte(keyByte), .dispValid(dispValid),
    .dispByte(dispByte), .dispReady(dispReady), .irq(irq)
  );

  function automatic logic isOurs(input logic [15:0] a);
    return (a == A_KS) || (a == A_KD) || (a == A_DS) || (a == A_DD);
  endfunction

  function automatic logic [15:0] expRead(input logic [15:0] a);
    case (a)
      A_KS:    return {mKRdy, mKIe, 14'b0};
      A_KD:    return {8'h00, mKByte};
      A_DS:    return {mDRdy, mDIe, 14'b0};
      A_DD:    return {8'h00, mDByte};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string readTag(input logic [15:0] a);
    case (a)
      A_KS:    return "R3";
      A_KD:    return "R4";
      A_DS:    return "R9";
      A_DD:    return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    string t;
    t = (forceTag != "") ? forceTag : tag;
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mKRdy = 0; mKIe = 0; mKByte = 0; mDRdy = 1; mDIe = 0; mDByte = 0; mPend = 0;
  endtask

  // One bus cycle: drive at negedge, check outputs before the edge, advance model.
  task automatic cyc(input logic rd, input logic wr, input logic [15:0] a,
                     input logic [15:0] wd, input logic kv, input logic [7:0] kb,
                     input logic sk);
    logic [15:0] er;
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWdata = wd;
    keyValid = kv; keyByte = kb; dispReady = sk;
    #1;
    er = rd ? expRead(a) : 16'h0;
    chk(busRdata === er, readTag(a), "busRdata", busRdata, er);
    chk(busHit === ((rd | wr) & isOurs(a)), "R1", "busHit", {15'b0, busHit},
        {15'b0, (rd | wr) & isOurs(a)});
    chk(irq === ((mKRdy & mKIe) | (mDRdy & mDIe)), "R10", "irq", {15'b0, irq},
        {15'b0, (mKRdy & mKIe) | (mDRdy & mDIe)});
    chk(dispValid === mPend, "R7", "dispValid", {15'b0, dispValid}, {15'b0, mPend});
    chk(dispByte === mDByte, "R8", "dispByte", {8'b0, dispByte}, {8'b0, mDByte});
    // model next state
    if (kv) begin mKByte = kb; mKRdy = 1; end
    else if (rd && a == A_KD) mKRdy = 0;
    if (wr && a == A_KS) mKIe = wd[14];
    if (wr && a == A_DS) mDIe = wd[14];
    if (wr && a == A_DD && mDRdy) begin mDByte = wd[7:0]; mDRdy = 0; mPend = 1; end
    else if (mPend && sk) begin mPend = 0; mDRdy = 1; end
    @(posedge clk);
    #0.5;
    busRd = 0; busWr = 0; keyValid = 0; dispReady = 0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    logic [15:0] addrPool [8];
    void'($urandom(32'd2024));
    addrPool = '{A_KS, A_KD, A_DS, A_DD, 16'hFE01, 16'hFE08, 16'h3000, 16'hFDFE};
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: reset state of every word
    forceTag = "R2";
    cyc(1, 0, A_KS, 0, 0, 0, 0);
    cyc(1, 0, A_KD, 0, 0, 0, 0);
    cyc(1, 0, A_DS, 0, 0, 0, 0);
    cyc(1, 0, A_DD, 0, 0, 0, 0);
    forceTag = "";

    // R3, R4: arrival then read-clear
    cyc(0, 0, 0, 0, 1, 8'h43, 0);
    cyc(1, 0, A_KS, 0, 0, 0, 0);
    cyc(1, 0, A_KD, 0, 0, 0, 0);
    cyc(1, 0, A_KS, 0, 0, 0, 0);

    // R5: arrival and data read in the same cycle
    forceTag = "R5";
    cyc(0, 0, 0, 0, 1, 8'h11, 0);
    cyc(1, 0, A_KD, 0, 1, 8'h22, 0);
    cyc(1, 0, A_KS, 0, 0, 0, 0);
    cyc(1, 0, A_KD, 0, 0, 0, 0);
    forceTag = "";

    // R9: status write with all bits set, kbd data write ignored
    forceTag = "R9";
    cyc(0, 1, A_KS, 16'hFFFF, 0, 0, 0);
    cyc(0, 1, A_DS, 16'hFFFF, 0, 0, 0);
    cyc(1, 0, A_KS, 0, 0, 0, 0);
    cyc(0, 1, A_KD, 16'h00AA, 0, 0, 0);
    cyc(1, 0, A_KD, 0, 0, 0, 0);
    forceTag = "";

    // R6, R7, R8: display write, busy write ignored, hold, handshake
    forceTag = "R8";
    cyc(0, 1, A_DD, 16'hAB47, 0, 0, 0);
    cyc(0, 1, A_DD, 16'h0058, 0, 0, 0);
    cyc(1, 0, A_DS, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, A_DS, 0, 0, 0, 0);
    cyc(1, 0, A_DD, 0, 0, 0, 0);
    forceTag = "";

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [15:0] a;
      op = $urandom_range(0, 9);
      a  = addrPool[$urandom_range(0, 7)];
      case (op)
        0, 1:    cyc(1, 0, a, 0, ($urandom_range(0, 3) == 0), 8'($urandom), ($urandom_range(0, 1) == 1));
        2:       cyc(1, 0, A_KD, 0, ($urandom_range(0, 2) == 0), 8'($urandom), 0);
        3:       cyc(0, 1, ($urandom_range(0, 1) ? A_KS : A_DS), 16'($urandom), 0, 0, 0);
        4, 5:    cyc(0, 1, A_DD, 16'($urandom), 0, 0, ($urandom_range(0, 1) == 1));
        6:       cyc(0, 1, a, 16'($urandom), ($urandom_range(0, 1) == 1), 8'($urandom), 0);
        default: cyc(0, 0, 0, 0, ($urandom_range(0, 1) == 1), 8'($urandom), ($urandom_range(0, 1) == 1));
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule